// File: doc/BRIEF.md
# Reset and Low-Power Sequencer

This block decides when a small microcontroller core is held in reset, when its CPU clock runs, when its peripherals are clocked and when the oscillator is allowed to run. It filters the external reset pin so that only a pulse lasting two machine cycles of running oscillator reaches the core. It carries the core in and out of two low-power states. In the light state only the CPU clock stops. In the deep state the oscillator itself is switched off, and only the reset pin or a correctly configured external interrupt line brings the part back.

The sequencing logic runs from an always-present reference clock `clk_i`, one cycle of which stands for one oscillator period. The internal clock is a divide-by-two of that period, so each clock enable pulses on every second cycle. A supply-good input acts as the asynchronous power-on reset of the whole block and also sets a software-visible power-off flag. Every pin is a plain level or single-cycle strobe. The block carries no data stream, so there is no valid/ready handshake and no back-pressure. Inputs are assumed to be synchronous to `clk_i`.

Top module: `lpm_ctrl`

## Requirements
- R1: While `pwr_ok_i` is low, `sys_rst_o`=1, `pof_o`=1, `osc_en_o`=1 and both clock enables and `ram_inh_o` are 0. `flag_we_i` loads `flag_wd_i` into `pof_o` on the next edge. A reset coming from the pin leaves `pof_o` unchanged.
- R2: `sys_rst_o` rises on the edge at which `rst_pin_i` has been sampled high on 24 consecutive edges (OSC_PER_MC x RST_MC) with the oscillator enabled. A pulse of 23 samples has no effect. `sys_rst_o` falls on the first edge at which the pin is sampled low.
- R3: In the running state, `cpu_clk_en_o` and `per_clk_en_o` pulse on every second edge, giving 4 pulses in any 8 consecutive cycles.
- R4: An `idle_req_i` strobe in the running state stops `cpu_clk_en_o` from the next edge. `per_clk_en_o` keeps pulsing and `osc_en_o` stays 1.
- R5: In idle, `irq_pend_i` returns the core to the running state on the next edge.
- R6: A `pd_req_i` strobe in the running state drives `osc_en_o` and both enables to 0 from the next edge. If both strobes arrive in the same cycle, `pd_req_i` wins.
- R7: In power-down, `irq_pend_i` has no effect, and neither has a low external line whose enable bit is 0 or whose mode bit is 0 (edge mode). `osc_en_o` stays 0.
- R8: In power-down, an external line that is low with its enable=1 and mode=1 (level) sets `osc_en_o` on the next edge. `cpu_clk_en_o` stays 0 until STAB_CYC (16) cycles of stabilization have elapsed and every such line is high again. The CPU clock then resumes.
- R9: A high reset pin during idle ends idle on the next edge, so the CPU resumes, and raises `ram_inh_o`. `ram_inh_o` falls on the edge where `sys_rst_o` rises, or on the first edge with the pin low.
- R10: A high reset pin in power-down sets `osc_en_o` on the next edge. Qualification counts only from that edge, so `sys_rst_o` rises 25 edges after the pin goes high. After the pin is released the core runs.
- R11: While `sys_rst_o` is 1, idle and power-down strobes are ignored and the core comes out of reset in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock, one oscillator period per cycle |
| pwr_ok_i | input | 1 | Supply good, active-low asynchronous power-on reset |
| rst_pin_i | input | 1 | External reset pin, active high |
| idle_req_i | input | 1 | Single-cycle idle request |
| pd_req_i | input | 1 | Single-cycle power-down request |
| irq_pend_i | input | 1 | Some enabled interrupt is pending |
| ext_int_n_i | input | N_EXT | External interrupt lines, active low |
| ext_int_en_i | input | N_EXT | Per-line interrupt enable |
| ext_int_lvl_i | input | N_EXT | Per-line mode, 1 = level sensitive |
| flag_we_i | input | 1 | Software write strobe for the power-off flag |
| flag_wd_i | input | 1 | Value written to the flag |
| sys_rst_o | output | 1 | Internal reset |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ram_inh_o | output | 1 | Internal RAM access inhibit |
| pof_o | output | 1 | Power-off flag |

## Verification
The hardest states to reach are the two deep-sleep exits, because the oscillator has to be off first. Each one needs an idle or power-down strobe followed by precisely timed pin activity. The stimulus enters power-down with a strobe and then drops a level-mode line. It releases the line once early (before the stabilization count ends) and once late (after it), and it checks that the CPU enable stays quiet across the whole window. The RAM inhibit window is reached by raising the reset pin while in idle and holding it for the full qualification time, and in a second run releasing it early.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_PD_OFF  = 3'd2,
    ST_PD_WAKE = 3'd3,
    ST_PD_RSTW = 3'd4
  } lpm_state_t;

endpackage

// File: rtl/lpm_rst_qual.sv
// Counts consecutive high samples of the reset pin while the oscillator
// runs; asserts the internal reset once the full window has been seen.
module lpm_rst_qual #(
  parameter int QUAL_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic osc_run_i,
  output logic fire_o,
  output logic sys_rst_o
);
  localparam int CW = (QUAL_CYC > 2) ? $clog2(QUAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  assign fire_o    = pin_i && osc_run_i && (cnt_q == LAST);
  assign sys_rst_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!pin_i) begin
      cnt_q <= '0;
    end else if (osc_run_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
    end else if (!pin_i) begin
      rst_q <= 1'b0;
    end else if (fire_o) begin
      rst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lpm_clk_div.sv
// Divide-by-two phase: one enable pulse every second oscillator period.
module lpm_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else if (run_i) begin
      phase_q <= ~phase_q;
    end
  end

  assign tick_o = run_i && phase_q;
endmodule

// File: rtl/lpm_stab_cnt.sv
// Oscillator stabilization down-counter, loaded when the oscillator restarts.
module lpm_stab_cnt #(
  parameter int STAB_CYC = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  output logic [$clog2(STAB_CYC+1)-1:0]    left_o,
  output logic                             done_o
);
  localparam int SW = $clog2(STAB_CYC + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= SW'(STAB_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign left_o = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_wake_sel.sv
// Picks the external lines allowed to end power-down: enabled, level mode, low.
module lpm_wake_sel #(
  parameter int N_EXT = 2
) (
  input  logic [N_EXT-1:0] pin_n_i,
  input  logic [N_EXT-1:0] en_i,
  input  logic [N_EXT-1:0] lvl_i,
  output logic             wake_o
);
  logic [N_EXT-1:0] elig;

  for (genvar g = 0; g < N_EXT; g++) begin : g_line
    assign elig[g] = en_i[g] && lvl_i[g] && !pin_n_i[g];
  end

  assign wake_o = |elig;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int STAB_CYC   = 16,
  parameter int N_EXT      = 2
) (
  input  logic             clk_i,
  input  logic             pwr_ok_i,
  input  logic             rst_pin_i,
  input  logic             idle_req_i,
  input  logic             pd_req_i,
  input  logic             irq_pend_i,
  input  logic [N_EXT-1:0] ext_int_n_i,
  input  logic [N_EXT-1:0] ext_int_en_i,
  input  logic [N_EXT-1:0] ext_int_lvl_i,
  input  logic             flag_we_i,
  input  logic             flag_wd_i,
  output logic             sys_rst_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             ram_inh_o,
  output logic             pof_o
);
  localparam int QUAL_CYC = OSC_PER_MC * RST_MC;
  localparam int STAB_W   = $clog2(STAB_CYC + 1);

  lpm_state_t        state_q, state_d;
  logic              osc_run, fire, sys_rst_q, tick;
  logic              wake_any, stab_load, stab_done;
  logic [STAB_W-1:0] stab_left;
  logic              ram_inh_q, pof_q;

  assign osc_run = (state_q != ST_PD_OFF);

  lpm_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (pwr_ok_i),
    .pin_i     (rst_pin_i),
    .osc_run_i (osc_run),
    .fire_o    (fire),
    .sys_rst_o (sys_rst_q)
  );

  lpm_clk_div u_div (
    .clk_i  (clk_i),
    .rst_ni (pwr_ok_i),
    .run_i  (osc_run),
    .tick_o (tick)
  );

  lpm_wake_sel #(.N_EXT(N_EXT)) u_wake (
    .pin_n_i (ext_int_n_i),
    .en_i    (ext_int_en_i),
    .lvl_i   (ext_int_lvl_i),
    .wake_o  (wake_any)
  );

  lpm_stab_cnt #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (pwr_ok_i),
    .load_i (stab_load),
    .left_o (stab_left),
    .done_o (stab_done)
  );

  // Sequencing state machine
  always_comb begin
    state_d   = state_q;
    stab_load = 1'b0;
    if (sys_rst_q) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (pd_req_i)        state_d = ST_PD_OFF;
          else if (idle_req_i) state_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (rst_pin_i || irq_pend_i) state_d = ST_RUN;
        end
        ST_PD_OFF: begin
          if (rst_pin_i) begin
            state_d = ST_PD_RSTW;
          end else if (wake_any) begin
            state_d   = ST_PD_WAKE;
            stab_load = 1'b1;
          end
        end
        ST_PD_WAKE: begin
          if (stab_done && !wake_any) state_d = ST_RUN;
        end
        ST_PD_RSTW: begin
          if (!rst_pin_i) state_d = ST_PD_OFF;
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge pwr_ok_i) begin
    if (!pwr_ok_i) state_q <= ST_RUN;
    else           state_q <= state_d;
  end

  // RAM inhibit: idle left through the reset pin, until reset takes over
  always_ff @(posedge clk_i or negedge pwr_ok_i) begin
    if (!pwr_ok_i) begin
      ram_inh_q <= 1'b0;
    end else if (state_q == ST_IDLE && rst_pin_i && !sys_rst_q) begin
      ram_inh_q <= 1'b1;
    end else if (fire || !rst_pin_i) begin
      ram_inh_q <= 1'b0;
    end
  end

  // Power-off flag: set by supply power-up, written by software
  always_ff @(posedge clk_i or negedge pwr_ok_i) begin
    if (!pwr_ok_i)      pof_q <= 1'b1;
    else if (flag_we_i) pof_q <= flag_wd_i;
  end

  assign sys_rst_o    = sys_rst_q;
  assign osc_en_o     = osc_run;
  assign per_clk_en_o = tick && (state_q == ST_RUN || state_q == ST_IDLE);
  assign cpu_clk_en_o = tick && (state_q == ST_RUN);
  assign ram_inh_o    = ram_inh_q;
  assign pof_o        = pof_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int N_EXT  = 2,
  parameter int STAB_W = 5
) (
  input logic             clk_i,
  input logic             pwr_ok_i,
  input logic             rst_pin_i,
  input logic             idle_req_i,
  input logic             pd_req_i,
  input logic [N_EXT-1:0] ext_int_n_i,
  input logic [N_EXT-1:0] ext_int_en_i,
  input logic [N_EXT-1:0] ext_int_lvl_i,
  input logic             flag_we_i,
  input logic             flag_wd_i,
  input logic             sys_rst_o,
  input logic             cpu_clk_en_o,
  input logic             per_clk_en_o,
  input logic             osc_en_o,
  input logic             ram_inh_o,
  input logic             pof_o,
  input lpm_state_t       state_q,
  input logic [STAB_W-1:0] stab_left
);
  logic [N_EXT-1:0] line_ok;
  assign line_ok = ~ext_int_n_i & ext_int_en_i & ext_int_lvl_i;

  a_r1_flag_write: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    flag_we_i |=> (pof_o == $past(flag_wd_i)));

  a_r2_release: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    !rst_pin_i |=> !sys_rst_o);

  a_r3_cpu_half: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    cpu_clk_en_o |=> !cpu_clk_en_o);

  a_r3_per_half: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    per_clk_en_o |=> !per_clk_en_o);

  a_r4_idle_stop: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    (state_q == ST_RUN && idle_req_i && !pd_req_i && !sys_rst_o) |=> (!cpu_clk_en_o && osc_en_o));

  a_r6_pd_osc_off: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    (state_q == ST_RUN && pd_req_i && !sys_rst_o) |=> !osc_en_o);

  a_r7_stay_off: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    (state_q == ST_PD_OFF && !rst_pin_i && line_ok == '0 && !sys_rst_o) |=> !osc_en_o);

  a_r8_hold_cpu: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    (state_q == ST_PD_WAKE && stab_left != '0 && !sys_rst_o) |=> !cpu_clk_en_o);

  a_r9_inhibit: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    (state_q == ST_IDLE && rst_pin_i && !sys_rst_o) |=> (ram_inh_o && state_q == ST_RUN));

  a_r11_reset_runs: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    sys_rst_o |=> (state_q == ST_RUN));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_EXT(N_EXT), .STAB_W(STAB_W)) u_chk (
  .clk_i         (clk_i),
  .pwr_ok_i      (pwr_ok_i),
  .rst_pin_i     (rst_pin_i),
  .idle_req_i    (idle_req_i),
  .pd_req_i      (pd_req_i),
  .ext_int_n_i   (ext_int_n_i),
  .ext_int_en_i  (ext_int_en_i),
  .ext_int_lvl_i (ext_int_lvl_i),
  .flag_we_i     (flag_we_i),
  .flag_wd_i     (flag_wd_i),
  .sys_rst_o     (sys_rst_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .per_clk_en_o  (per_clk_en_o),
  .osc_en_o      (osc_en_o),
  .ram_inh_o     (ram_inh_o),
  .pof_o         (pof_o),
  .state_q       (state_q),
  .stab_left     (stab_left)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 16;

  localparam logic [5:0] M_RST = 6'b100000;
  localparam logic [5:0] M_CPU = 6'b010000;
  localparam logic [5:0] M_PER = 6'b001000;
  localparam logic [5:0] M_OSC = 6'b000100;
  localparam logic [5:0] M_RAM = 6'b000010;
  localparam logic [5:0] M_POF = 6'b000001;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b0, rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_en = 2'b00, ext_lvl = 2'b00;
  logic       flag_we = 1'b0, flag_wd = 1'b0;
  logic       sys_rst, cpu_en, per_en, osc_en, ram_inh, pof;
  logic [5:0] outs;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit fin = 0;

  int         due_q[$];
  string      tag_q[$];
  logic [5:0] mask_q[$];
  logic [5:0] val_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpm_ctrl u0 (
    .clk_i(clk), .pwr_ok_i(pwr_ok), .rst_pin_i(rst_pin), .idle_req_i(idle_req),
    .pd_req_i(pd_req), .irq_pend_i(irq), .ext_int_n_i(ext_n), .ext_int_en_i(ext_en),
    .ext_int_lvl_i(ext_lvl), .flag_we_i(flag_we), .flag_wd_i(flag_wd),
    .sys_rst_o(sys_rst), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_en_o(osc_en), .ram_inh_o(ram_inh), .pof_o(pof)
  );

  assign outs = {sys_rst, cpu_en, per_en, osc_en, ram_inh, pof};

  // Driver side: expected output bits due k edges from now
  task automatic expect_at(input int k, input string tag, input logic [5:0] m, input logic [5:0] v);
    due_q.push_back(cyc + k);
    tag_q.push_back(tag);
    mask_q.push_back(m);
    val_q.push_back(v);
  endtask

  task automatic expect_span(input int k0, input int k1, input string tag,
                             input logic [5:0] m, input logic [5:0] v);
    for (int k = k0; k <= k1; k++) expect_at(k, tag, m, v);
  endtask

  // Monitor side: pops due items and compares
  always @(negedge clk) begin
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        n_chk++;
        if ((outs & mask_q[i]) != (val_q[i] & mask_q[i])) begin
          n_fail++;
          $display("FAIL %s: outputs %b expected %b under mask %b at cycle %0d",
                   tag_q[i], outs, val_q[i], mask_q[i], cyc);
        end
        due_q.delete(i);
        tag_q.delete(i);
        mask_q.delete(i);
        val_q.delete(i);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_pulses(input int n, output int c_cpu, output int c_per);
    c_cpu = 0;
    c_per = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_cpu += int'(cpu_en);
      c_per += int'(per_en);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit do_idle, input bit do_pd);
    @(negedge clk);
    idle_req = do_idle;
    pd_req   = do_pd;
    @(negedge clk);
    idle_req = 1'b0;
    pd_req   = 1'b0;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc != target) @(negedge clk);
  endtask

  initial begin
    int c, nc, np;
    step(3);
    // R1 reset state
    chk("R1 sys_rst at power-up", int'(sys_rst), 1);
    chk("R1 pof at power-up", int'(pof), 1);
    chk("R1 osc_en at power-up", int'(osc_en), 1);
    chk("R1 enables/inhibit idle at power-up", int'({cpu_en, per_en, ram_inh}), 0);
    pwr_ok = 1'b1;
    expect_at(1, "R2 reset released with pin low", M_RST | M_OSC, M_OSC);
    step(3);

    // R3 divide-by-two
    count_pulses(8, nc, np);
    chk("R3 cpu pulses in 8 cycles", nc, 4);
    chk("R3 per pulses in 8 cycles", np, 4);

    // R1 software write
    @(negedge clk); flag_we = 1'b1; flag_wd = 1'b0;
    expect_at(1, "R1 flag cleared by write", M_POF, 6'b0);
    @(negedge clk); flag_we = 1'b0;
    step(2);

    // R2 short pulse of 23 samples
    @(negedge clk); rst_pin = 1'b1;
    expect_at(23, "R2 no reset before 24 samples", M_RST, 6'b0);
    expect_at(24, "R2 23-sample pulse ignored", M_RST, 6'b0);
    step(23); rst_pin = 1'b0;
    step(4);

    // R2 full qualification, R11 strobe ignored, R1 flag kept
    @(negedge clk); rst_pin = 1'b1;
    expect_at(23, "R2 reset not yet asserted", M_RST, 6'b0);
    expect_at(24, "R2 reset asserted after 24 samples", M_RST | M_POF, M_RST);
    step(26);
    strobe(1'b0, 1'b1);
    step(2);
    @(negedge clk); rst_pin = 1'b0;
    expect_at(1, "R11 reset released, oscillator still on", M_RST | M_OSC | M_POF, M_OSC);
    step(2);
    count_pulses(8, nc, np);
    chk("R11 core running after reset despite strobe", nc, 4);
    @(negedge clk); flag_we = 1'b1; flag_wd = 1'b1;
    expect_at(1, "R1 flag set by write", M_POF, M_POF);
    @(negedge clk); flag_we = 1'b0;

    // R4 idle
    @(negedge clk); idle_req = 1'b1;
    expect_span(1, 8, "R4 cpu stopped, osc on in idle", M_CPU | M_OSC, M_OSC);
    @(negedge clk); idle_req = 1'b0;
    count_pulses(8, nc, np);
    chk("R4 peripheral pulses continue in idle", np, 4);
    chk("R4 cpu pulses in idle", nc, 0);

    // R5 interrupt ends idle
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    count_pulses(8, nc, np);
    chk("R5 cpu resumed after interrupt", nc, 4);

    // R6 both strobes: power-down wins
    @(negedge clk); idle_req = 1'b1; pd_req = 1'b1;
    expect_at(1, "R6 power-down wins, all stopped", M_OSC | M_CPU | M_PER, 6'b0);
    @(negedge clk); idle_req = 1'b0; pd_req = 1'b0;

    // R7 ineligible wake sources
    @(negedge clk);
    irq = 1'b1; ext_en = 2'b01; ext_lvl = 2'b10; ext_n = 2'b00;
    expect_span(1, 10, "R7 oscillator stays off", M_OSC | M_CPU, 6'b0);
    step(10);
    irq = 1'b0; ext_n = 2'b11;
    step(2);

    // R8 wake, pin released early
    ext_en = 2'b11; ext_lvl = 2'b11;
    @(negedge clk); ext_n = 2'b10; c = cyc;
    expect_at(1, "R8 oscillator restarts", M_OSC, M_OSC);
    expect_span(1, STAB + 1, "R8 cpu held during stabilization", M_CPU, 6'b0);
    step(3); ext_n = 2'b11;
    wait_cyc(c + STAB + 1);
    count_pulses(6, nc, np);
    chk("R8 cpu resumed after stabilization", nc, 3);

    // R8 wake, pin held beyond stabilization
    strobe(1'b0, 1'b1);
    @(negedge clk); ext_n = 2'b01; c = cyc;
    expect_span(1, 25, "R8 cpu held while line low", M_CPU | M_OSC, M_OSC);
    step(25); ext_n = 2'b11;
    count_pulses(6, nc, np);
    chk("R8 cpu resumed after line high", nc, 3);

    // R9 reset pin during idle, held through qualification
    strobe(1'b1, 1'b0);
    @(negedge clk); rst_pin = 1'b1;
    expect_at(1, "R9 inhibit raised", M_RAM | M_RST, M_RAM);
    expect_at(23, "R9 inhibit held before reset", M_RAM | M_RST, M_RAM);
    expect_at(24, "R9 inhibit dropped as reset asserts", M_RAM | M_RST, M_RST);
    @(negedge clk);
    count_pulses(8, nc, np);
    chk("R9 cpu resumed before reset", nc, 4);
    step(20);
    @(negedge clk); rst_pin = 1'b0;
    expect_at(1, "R9 reset released", M_RST | M_RAM, 6'b0);
    step(3);

    // R9 short pin pulse in idle
    strobe(1'b1, 1'b0);
    @(negedge clk); rst_pin = 1'b1;
    expect_at(1, "R9 inhibit raised on short pulse", M_RAM, M_RAM);
    step(5); rst_pin = 1'b0;
    expect_at(1, "R9 inhibit cleared by pin low", M_RAM | M_RST, 6'b0);
    step(3);

    // R10 reset pin in power-down
    strobe(1'b0, 1'b1);
    @(negedge clk); rst_pin = 1'b1;
    expect_at(1, "R10 oscillator restarted by pin", M_OSC, M_OSC);
    expect_at(24, "R10 reset not yet asserted", M_RST, 6'b0);
    expect_at(25, "R10 reset asserted", M_RST, M_RST);
    step(27);
    @(negedge clk); rst_pin = 1'b0;
    expect_at(1, "R10 reset released", M_RST | M_OSC, M_OSC);
    step(2);
    count_pulses(8, nc, np);
    chk("R10 core running after power-down reset", nc, 4);

    while (due_q.size() != 0) @(negedge clk);
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule